// File: doc/BRIEF.md
# Latched Parallel-to-Serial Converter

This block turns an 8-bit parallel word into a serial bit stream through two register stages. A holding stage samples the parallel input whenever its capture strobe is high at a clock edge. A shift stage then either copies the held word in one step or moves its contents one place toward the last stage, taking a new bit from a serial input at the first stage. The holding stage has its own strobe, so software or upstream logic can capture the next word while the current one is still being sent.

Only the last stage leaves the block. It drives a serial output that goes to high impedance when the active-low output enable is released, so several converters can share one receive line of a standard SPI-style serial port. A separate drive flag reports whether the output is driven. Both strobes act on one clock, so the whole block is synchronous. Bit 0 of the parallel word is the first stage and bit WIDTH-1 is the last stage. The last stage is sent first.

Top module: `lpso_top`

## Requirements
- R1: A clock edge with `rst_n` low clears the holding stage and the shift stage to all zeros.
- R2: The holding stage takes `par_in` on a clock edge with `cap_en` high and keeps its value on every other edge.
- R3: On a clock edge with `shf_en` high and `load_n` low, the shift stage takes the held word. `ser_out` then equals bit WIDTH-1 of that word.
- R4: On a clock edge with `shf_en` high and `load_n` high, every stage i takes stage i-1 and stage 0 takes `ser_in`. `ser_out` therefore shows the loaded word from bit WIDTH-1 down to bit 0, then the serial bits in the order they were fed.
- R5: On a clock edge with `shf_en` low, the shift stage keeps its contents.
- R6: While `oe_n` is high, `ser_drv` is low and `ser_out` is high impedance. While `oe_n` is low, `ser_drv` is high and `ser_out` drives the last stage. `oe_n` changes no register.
- R7: If `cap_en` and a load occur at the same edge, the shift stage takes the word that was held before that edge. The new word is kept for the next load.
- R8: A capture during shifting leaves the bits already in the shift stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| par_in | input | 8 | Parallel word; bit 0 is the first stage |
| cap_en | input | 1 | Capture strobe for the holding stage |
| shf_en | input | 1 | Advance strobe for the shift stage |
| load_n | input | 1 | Low: load the held word; high: shift |
| ser_in | input | 1 | Serial bit entering stage 0 |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last stage, high impedance when disabled |
| ser_drv | output | 1 | High when `ser_out` is driven |

## Verification
A wrong value in the holding stage cannot be seen until the next load. After that load the last stage shows the bad top bit at once, and each lower bit appears one shift later, so one full word of shifts exposes every bit. A bad shift-stage bit reaches `ser_out` after as many shifts as it is away from the last stage, which is at most WIDTH-1 edges. Enable faults show up on `ser_drv` in the same cycle. The bench also checks that disabling the output disturbs no state by re-enabling it and reading the word back.

// File: rtl/lpso_pkg.sv
package lpso_pkg;
   localparam int unsigned LPSO_WIDTH = 8;
   typedef enum logic [1:0] {
      SH_HOLD  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_LOAD  = 2'd2
   } sh_op_e;
endpackage

// File: rtl/lpso_hold.sv
module lpso_hold #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] held
);
   initial begin
      if (WIDTH < 2) $error("lpso_hold: WIDTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      held <= '0;
      else if (cap_en) held <= par_in;
   end
endmodule

// File: rtl/lpso_shift.sv
module lpso_shift
   import lpso_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sh_op_e           op,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] held,
   output logic [WIDTH-1:0] stages
);
   initial begin
      if (WIDTH < 2) $error("lpso_shift: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic from_prev;
      if (i == 0) begin : g_first
         assign from_prev = ser_in;
      end else begin : g_rest
         assign from_prev = stages[i-1];
      end
      always_comb begin
         unique case (op)
            SH_LOAD:  nxt[i] = held[i];
            SH_SHIFT: nxt[i] = from_prev;
            default:  nxt[i] = stages[i];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stages <= '0;
      else        stages <= nxt;
   end
endmodule

// File: rtl/lpso_drive.sv
module lpso_drive #(
   parameter bit TRISTATE = 1'b1
) (
   input  logic oe_n,
   input  logic last_bit,
   output logic ser_out,
   output logic ser_drv
);
   assign ser_drv = ~oe_n;

   if (TRISTATE) begin : g_tri
      assign ser_out = ser_drv ? last_bit : 1'bz;
   end else begin : g_gated
      assign ser_out = ser_drv & last_bit;
   end
endmodule

// File: rtl/lpso_top.sv
module lpso_top
   import lpso_pkg::*;
#(
   parameter int unsigned WIDTH    = LPSO_WIDTH,
   parameter bit          TRISTATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             cap_en,
   input  logic             shf_en,
   input  logic             load_n,
   input  logic             ser_in,
   input  logic             oe_n,
   output logic             ser_out,
   output logic             ser_drv
);
   localparam int unsigned LAST = WIDTH - 1;

   initial begin
      if (WIDTH < 2) $error("lpso_top: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] held_q;
   logic [WIDTH-1:0] stage_q;
   sh_op_e           op;

   always_comb begin
      if (!shf_en)     op = SH_HOLD;
      else if (!load_n) op = SH_LOAD;
      else             op = SH_SHIFT;
   end

   lpso_hold #(.WIDTH(WIDTH)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .par_in (par_in),
      .held   (held_q)
   );

   lpso_shift #(.WIDTH(WIDTH)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .ser_in (ser_in),
      .held   (held_q),
      .stages (stage_q)
   );

   lpso_drive #(.TRISTATE(TRISTATE)) u_drive (
      .oe_n     (oe_n),
      .last_bit (stage_q[LAST]),
      .ser_out  (ser_out),
      .ser_drv  (ser_drv)
   );
endmodule

// File: rtl/lpso_checker.sv
module lpso_checker #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cap_en,
   input logic             shf_en,
   input logic             load_n,
   input logic             ser_in,
   input logic             oe_n,
   input logic [WIDTH-1:0] par_in,
   input logic [WIDTH-1:0] held_q,
   input logic [WIDTH-1:0] stage_q,
   input logic             ser_drv
);
   AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> held_q == $past(par_in)); // R2
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(held_q)); // R2
   AST_LOAD_OLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_en && !load_n) |=> stage_q == $past(held_q)); // R7
   AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_en && load_n) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}); // R4
   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !shf_en |=> $stable(stage_q)); // R5
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !ser_drv); // R6
endmodule

bind lpso_top lpso_checker #(.WIDTH(WIDTH)) u_lpso_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .cap_en  (cap_en),
   .shf_en  (shf_en),
   .load_n  (load_n),
   .ser_in  (ser_in),
   .oe_n    (oe_n),
   .par_in  (par_in),
   .held_q  (held_q),
   .stage_q (stage_q),
   .ser_drv (ser_drv)
);

// File: tb/lpso_top_tb.sv
`timescale 1ns/1ps
module lpso_top_tb_top;
   localparam int W = 8;
   localparam int NV = 4;
   // each vector: {parallel word, serial byte fed MSB first}
   localparam logic [2*W-1:0] VEC [NV] = '{
      16'hA5_3C, 16'h81_FF, 16'h00_96, 16'h7E_01
   };

   logic clk = 1'b0;
   logic rst_n, cap_en, shf_en, load_n, ser_in, oe_n;
   logic [W-1:0] par_in;
   wire ser_out;
   wire ser_drv;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lpso_top dut_i (
      .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_en(cap_en),
      .shf_en(shf_en), .load_n(load_n), .ser_in(ser_in), .oe_n(oe_n),
      .ser_out(ser_out), .ser_drv(ser_drv)
   );

   task automatic step(input logic cap, input logic shf, input logic ld_n,
                       input logic si, input logic [W-1:0] word);
      cap_en = cap; shf_en = shf; load_n = ld_n; ser_in = si; par_in = word;
      @(posedge clk); #2;
      cap_en = 1'b0; shf_en = 1'b0; load_n = 1'b1; ser_in = 1'b0;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] wa, wb, ser_b;
      logic last;
      rst_n = 1'b0; cap_en = 0; shf_en = 0; load_n = 1; ser_in = 0;
      oe_n = 1'b0; par_in = '0;
      // preload nonzero state, then reset
      rst_n = 1'b1;
      step(1, 0, 1, 0, 8'hFF);
      step(0, 1, 0, 0, 8'h00);
      rst_n = 1'b0;
      step(0, 0, 1, 0, 8'h00);
      rst_n = 1'b1;
      chk("R1 shift stage zero", ser_out, 1'b0);
      step(0, 1, 0, 0, 8'h00);
      chk("R1 holding stage zero", ser_out, 1'b0);
      chk("R6 driven when enabled", ser_drv, 1'b1);

      // table walk: capture, load, shift word out, then serial byte
      for (int v = 0; v < NV; v++) begin
         wa = VEC[v][2*W-1:W];
         ser_b = VEC[v][W-1:0];
         step(1, 0, 1, 0, wa);
         step(0, 1, 0, 0, 8'h00);
         chk("R3 load shows top bit", ser_out, wa[W-1]);
         for (int k = 1; k <= W; k++) begin
            step(0, 1, 1, ser_b[W-k], 8'h00);
            if (k < W) chk("R4 word bit", ser_out, wa[W-1-k]);
            else chk("R4 first serial bit", ser_out, ser_b[W-1]);
         end
         for (int k = 1; k < W; k++) begin
            step(0, 1, 1, 0, 8'h00);
            chk("R4 serial bit", ser_out, ser_b[W-1-k]);
         end
      end

      // R2: capture then idle cycles with other par_in values; load shows first
      step(1, 0, 1, 0, 8'h80);
      step(0, 0, 1, 0, 8'h00);
      step(0, 0, 1, 0, 8'h7F);
      step(0, 1, 0, 0, 8'h00);
      chk("R2 held word kept", ser_out, 1'b1);

      // R5: no shift strobe keeps stages
      step(1, 0, 1, 0, 8'h40);
      for (int k = 0; k < 3; k++) begin
         step(0, 0, 1, 1, 8'h00);
         chk("R5 idle keeps last stage", ser_out, 1'b1);
      end
      step(0, 1, 1, 0, 8'h00);
      chk("R5 lower stage kept", ser_out, 1'b0);

      // R6: disable, load, shift; re-enable and read state
      oe_n = 1'b1;
      #1;
      chk("R6 drive flag low", ser_drv, 1'b0);
      step(1, 0, 1, 0, 8'h40);
      step(0, 1, 0, 0, 8'h00);
      step(0, 1, 1, 0, 8'h00);
      chk("R6 still released", ser_drv, 1'b0);
      oe_n = 1'b0;
      #1;
      chk("R6 state intact", ser_out, 1'b1);
      chk("R6 drive flag high", ser_drv, 1'b1);

      // R7: capture and load at the same edge
      wa = 8'h2D; wb = 8'hD2;
      step(1, 0, 1, 0, wa);
      step(1, 1, 0, 0, wb);
      chk("R7 old word top bit", ser_out, wa[W-1]);
      step(0, 1, 1, 0, 8'h00);
      chk("R7 old word next bit", ser_out, wa[W-2]);
      // R8: capture mid-shift does not disturb stages
      step(1, 1, 1, 0, 8'h00);
      chk("R8 shift continues", ser_out, wa[W-3]);
      for (int k = 3; k < W; k++) begin
         step(0, 1, 1, 0, 8'h00);
         chk("R8 old word bits", ser_out, wa[W-1-k]);
      end
      step(0, 1, 0, 0, 8'h00);
      chk("R8 mid-shift capture loaded", ser_out, 1'b0);
      step(0, 0, 1, 0, 8'h00);
      last = ser_out;
      chk("R7 new word not yet loaded", last, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule